// File: doc/BRIEF.md
# Bus Ownership Handoff Handshake

This block moves ownership of a shared bus between a default master and a single alternate master over three handshake lines: a request line, a grant line and a grant-acknowledge line. The design has two sides that are independent of each other. The arbiter side sits beside the default master. It waits for that master to report that its current bus cycle has ended, then issues the grant. It keeps the default master off the bus with a hold output until the acknowledge line shows that the alternate master has claimed the bus and has later let it go. The requester side sits beside the alternate master. It raises the request and waits for a grant while the acknowledge line is idle. It then claims the bus by driving acknowledge and only after that withdraws the request. It keeps acknowledge asserted for as long as it performs its transfers.

The two sides connect through ordinary wires. In a system, the arbiter's grant output drives the requester's grant input, and the requester's request and acknowledge outputs drive the arbiter's inputs. The acknowledge line is the OR of every device that can drive it. Every line that crosses between the sides passes through a synchronizer of `SYNC_STAGES` flops (default two) before any state machine uses it. All lines are active high.

Top module: `busown_hs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `arb_grant_o`, `dm_hold`, `alt_req_o`, `alt_ack_o` and `alt_owner` are all 0.
- R2: With the arbiter idle, `dm_cycle_done` high and the acknowledge line low, `arb_grant_o` and `dm_hold` rise on the third rising clock edge after the edge that first samples `arb_req_i` high.
- R3: The arbiter does not grant while `dm_cycle_done` is low. Once the synchronized request is present, the grant follows on the first edge that samples `dm_cycle_done` high.
- R4: The grant stays high until the synchronized acknowledge is seen. It then falls on the third edge after the edge that first samples `arb_ack_i` high, and `dm_hold` stays high.
- R5: After the alternate master releases (`arb_ack_i` falls), `dm_hold` falls on the fourth edge after the edge that first samples `arb_ack_i` low. This covers two synchronizer edges, the OWNED to RELEASE step and the RELEASE to IDLE step.
- R6: If the request is withdrawn while the grant is pending and no acknowledge has been seen, `arb_grant_o` and `dm_hold` both fall on the third edge after the edge that first samples `arb_req_i` low.
- R7: The arbiter never raises a grant while the synchronized acknowledge line is high, even with a request pending.
- R8: `alt_req_o` rises on the first edge that samples `alt_want` high in idle. `alt_ack_o` rises on the third edge after the edge that first samples `alt_grant_i` high, provided `alt_ack_i` is low.
- R9: The requester does not claim the bus while `alt_ack_i` is high, whatever the grant. It claims on the third edge after the edge that first samples `alt_ack_i` low.
- R10: At the claim, `alt_ack_o` and `alt_req_o` are both high for exactly one cycle. After that cycle, `alt_req_o` is 0, `alt_ack_o` is 1 and `alt_owner` is 1.
- R11: While it owns the bus, the requester ignores `alt_want` and the grant input. The edge that samples `alt_finish` high clears `alt_ack_o` and `alt_owner`.
- R12: If `alt_want` falls while the requester is waiting for a grant, `alt_req_o` falls on the next edge.
- R13: With the two sides wired together in a loop, a request ends with `alt_owner` high, `dm_hold` high and `arb_grant_o` low. After `alt_finish`, `dm_hold` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dm_cycle_done | input | 1 | Default master has no bus cycle in progress |
| dm_hold | output | 1 | Keeps the default master off the bus |
| arb_req_i | input | 1 | Request line as seen by the arbiter |
| arb_ack_i | input | 1 | Acknowledge line as seen by the arbiter |
| arb_grant_o | output | 1 | Grant line driven by the arbiter |
| alt_want | input | 1 | Alternate master wants the bus |
| alt_finish | input | 1 | Alternate master has finished its transfers |
| alt_grant_i | input | 1 | Grant line as seen by the requester |
| alt_ack_i | input | 1 | Acknowledge line (wired OR) as seen by the requester |
| alt_req_o | output | 1 | Request line driven by the requester |
| alt_ack_o | output | 1 | Acknowledge driven by the requester |
| alt_owner | output | 1 | Requester may run bus cycles |

## Verification
On every cycle, the assertions check several step relations. A grant can only rise when the request was present, the acknowledge line was idle and the default master had finished its cycle. A grant is always covered by hold. A claim is always made with the request still high and only after an idle acknowledge line and a present grant. Ownership always starts with the request withdrawn, and a finish always clears the acknowledge. The exact latencies through the synchronizers are shown only by the bench's scenarios. These include the cycle counts for grant, hand-back and withdrawal, the blocking by a foreign acknowledge, and the full loop-connected handoff.

// File: rtl/busown_pkg.sv
`timescale 1ns/1ps
package busown_pkg;

    typedef enum logic [1:0] {
        AR_IDLE    = 2'd0,
        AR_GRANT   = 2'd1,
        AR_OWNED   = 2'd2,
        AR_RELEASE = 2'd3
    } arb_state_e;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_ASK  = 2'd1,
        RQ_TAKE = 2'd2,
        RQ_OWN  = 2'd3
    } rq_state_e;

    typedef struct packed {
        logic grant;
        logic hold;
    } arb_out_t;

    typedef struct packed {
        logic req;
        logic ack;
        logic owner;
    } rq_out_t;

    // Bit positions inside the synchronized line bundles.
    localparam int LINE_A = 0;
    localparam int LINE_B = 1;
    localparam int LINES  = 2;

    function automatic arb_out_t arb_decode(input arb_state_e s);
        arb_out_t o;
        o.grant = (s == AR_GRANT);
        o.hold  = (s != AR_IDLE);
        return o;
    endfunction

    function automatic rq_out_t rq_decode(input rq_state_e s);
        rq_out_t o;
        o.req   = (s == RQ_ASK) || (s == RQ_TAKE);
        o.ack   = (s == RQ_TAKE) || (s == RQ_OWN);
        o.owner = (s == RQ_OWN);
        return o;
    endfunction

endpackage

// File: rtl/busown_sync.sv
`timescale 1ns/1ps
module busown_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/busown_arb.sv
`timescale 1ns/1ps
module busown_arb
    import busown_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic ack_s,
    input  logic cycle_done,
    output logic grant,
    output logic hold
);
    arb_state_e state_q, state_d;
    arb_out_t   outs;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AR_IDLE:
                if (req_s && !ack_s && cycle_done) state_d = AR_GRANT;
            AR_GRANT:
                if (ack_s)       state_d = AR_OWNED;
                else if (!req_s) state_d = AR_IDLE;
            AR_OWNED:
                if (!ack_s) state_d = AR_RELEASE;
            AR_RELEASE:
                state_d = AR_IDLE;
            default:
                state_d = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= AR_IDLE;
        else     state_q <= state_d;
    end

    assign outs  = arb_decode(state_q);
    assign grant = outs.grant;
    assign hold  = outs.hold;
endmodule

// File: rtl/busown_req.sv
`timescale 1ns/1ps
module busown_req
    import busown_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic finish,
    input  logic grant_s,
    input  logic ack_s,
    output logic req,
    output logic ack,
    output logic owner
);
    rq_state_e state_q, state_d;
    rq_out_t   outs;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:
                if (want) state_d = RQ_ASK;
            RQ_ASK:
                if (!want)                  state_d = RQ_IDLE;
                else if (grant_s && !ack_s) state_d = RQ_TAKE;
            RQ_TAKE:
                state_d = RQ_OWN;
            RQ_OWN:
                if (finish) state_d = RQ_IDLE;
            default:
                state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RQ_IDLE;
        else     state_q <= state_d;
    end

    assign outs  = rq_decode(state_q);
    assign req   = outs.req;
    assign ack   = outs.ack;
    assign owner = outs.owner;
endmodule

// File: rtl/busown_hs.sv
`timescale 1ns/1ps
module busown_hs
    import busown_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dm_cycle_done,
    output logic dm_hold,
    input  logic arb_req_i,
    input  logic arb_ack_i,
    output logic arb_grant_o,
    input  logic alt_want,
    input  logic alt_finish,
    input  logic alt_grant_i,
    input  logic alt_ack_i,
    output logic alt_req_o,
    output logic alt_ack_o,
    output logic alt_owner
);
    logic [LINES-1:0] arb_raw, arb_syn;
    logic [LINES-1:0] rq_raw, rq_syn;

    assign arb_raw[LINE_A] = arb_req_i;
    assign arb_raw[LINE_B] = arb_ack_i;
    assign rq_raw[LINE_A]  = alt_grant_i;
    assign rq_raw[LINE_B]  = alt_ack_i;

    busown_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_arb_sync (
        .clk (clk),
        .rst (rst),
        .d   (arb_raw),
        .q   (arb_syn)
    );

    busown_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_rq_sync (
        .clk (clk),
        .rst (rst),
        .d   (rq_raw),
        .q   (rq_syn)
    );

    busown_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .req_s      (arb_syn[LINE_A]),
        .ack_s      (arb_syn[LINE_B]),
        .cycle_done (dm_cycle_done),
        .grant      (arb_grant_o),
        .hold       (dm_hold)
    );

    busown_req u_req (
        .clk     (clk),
        .rst     (rst),
        .want    (alt_want),
        .finish  (alt_finish),
        .grant_s (rq_syn[LINE_A]),
        .ack_s   (rq_syn[LINE_B]),
        .req     (alt_req_o),
        .ack     (alt_ack_o),
        .owner   (alt_owner)
    );
endmodule

// File: rtl/busown_chk.sv
`timescale 1ns/1ps
module busown_chk (
    input logic clk,
    input logic rst,
    input logic dm_cycle_done,
    input logic dm_hold,
    input logic arb_req_i,
    input logic arb_ack_i,
    input logic arb_grant_o,
    input logic alt_want,
    input logic alt_finish,
    input logic alt_grant_i,
    input logic alt_ack_i,
    input logic alt_req_o,
    input logic alt_ack_o,
    input logic alt_owner
);
    // R2, R3, R7: a grant needs a request, an idle acknowledge line and a finished cycle
    a_r7_grant_preconditions: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_grant_o) |-> ($past(arb_req_i, 3) && !$past(arb_ack_i, 3) && $past(dm_cycle_done)));

    // R4: the default master is held whenever a grant is out
    a_r4_grant_holds: assert property (@(posedge clk) disable iff (rst)
        arb_grant_o |-> dm_hold);

    // R9: claim only after a grant with the acknowledge line idle
    a_r9_claim_when_free: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_ack_o) |-> ($past(alt_grant_i, 3) && !$past(alt_ack_i, 3)));

    // R10: acknowledge rises while the request is still up
    a_r10_ack_before_drop: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_ack_o) |-> alt_req_o);

    // R10: ownership begins with the request withdrawn
    a_r10_owner_no_req: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_owner) |-> (!alt_req_o && alt_ack_o));

    // R11: finish while owning clears acknowledge on the next edge
    a_r11_finish_releases: assert property (@(posedge clk) disable iff (rst)
        (alt_owner && alt_finish) |=> !alt_ack_o);

    // R12: a withdrawn want while waiting drops the request
    a_r12_withdraw: assert property (@(posedge clk) disable iff (rst)
        (alt_req_o && !alt_ack_o && !alt_want) |=> !alt_req_o);
endmodule

bind busown_hs busown_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .dm_cycle_done (dm_cycle_done),
    .dm_hold       (dm_hold),
    .arb_req_i     (arb_req_i),
    .arb_ack_i     (arb_ack_i),
    .arb_grant_o   (arb_grant_o),
    .alt_want      (alt_want),
    .alt_finish    (alt_finish),
    .alt_grant_i   (alt_grant_i),
    .alt_ack_i     (alt_ack_i),
    .alt_req_o     (alt_req_o),
    .alt_ack_o     (alt_ack_o),
    .alt_owner     (alt_owner)
);

// File: tb/busown_hs_tb.sv
`timescale 1ns/1ps
module busown_hs_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tb_req = 1'b0, tb_ack = 1'b0, tb_done = 1'b0;
    logic tb_want = 1'b0, tb_finish = 1'b0, tb_grant = 1'b0, tb_altack = 1'b0;
    logic loopback = 1'b0;

    logic dm_hold, arb_grant_o, alt_req_o, alt_ack_o, alt_owner;
    logic arb_req_i, arb_ack_i, alt_grant_i, alt_ack_i;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    assign arb_req_i   = loopback ? alt_req_o   : tb_req;
    assign arb_ack_i   = loopback ? alt_ack_o   : tb_ack;
    assign alt_grant_i = loopback ? arb_grant_o : tb_grant;
    assign alt_ack_i   = loopback ? alt_ack_o   : tb_altack;

    busown_hs u_dut (
        .clk           (clk),
        .rst           (rst),
        .dm_cycle_done (tb_done),
        .dm_hold       (dm_hold),
        .arb_req_i     (arb_req_i),
        .arb_ack_i     (arb_ack_i),
        .arb_grant_o   (arb_grant_o),
        .alt_want      (tb_want),
        .alt_finish    (tb_finish),
        .alt_grant_i   (alt_grant_i),
        .alt_ack_i     (alt_ack_i),
        .alt_req_o     (alt_req_o),
        .alt_ack_o     (alt_ack_o),
        .alt_owner     (alt_owner)
    );

    always #4 clk = ~clk;

    // Arbiter vectors: {req, ack, done, expected grant, expected hold}
    localparam int NVEC = 28;
    localparam logic [4:0] ARB_VEC [NVEC] = '{
        5'b001_00, 5'b100_00, 5'b100_00, 5'b100_00, 5'b101_11,
        5'b110_11, 5'b010_11, 5'b010_01, 5'b010_01, 5'b000_01,
        5'b000_01, 5'b000_01, 5'b000_00,
        5'b101_00, 5'b101_00, 5'b001_11, 5'b001_11, 5'b001_00,
        5'b111_00, 5'b111_00, 5'b111_00, 5'b111_00, 5'b101_00,
        5'b101_00, 5'b101_11, 5'b001_11, 5'b001_11, 5'b001_00
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        if (i < 5)       return "R3 cycle-done gating";
        else if (i < 8)  return "R4 grant until ack";
        else if (i < 13) return "R5 release hand-back";
        else if (i < 15) return "R2 grant latency";
        else if (i < 18) return "R6 withdraw while granted";
        else             return "R7 no grant while ack busy";
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        chk("R1 grant in reset", arb_grant_o, 1'b0);
        chk("R1 hold in reset", dm_hold, 1'b0);
        step();
        rst = 1'b0;
        step();
        chk("R1 req after reset", alt_req_o, 1'b0);
        chk("R1 ack after reset", alt_ack_o, 1'b0);
        chk("R1 owner after reset", alt_owner, 1'b0);

        // Arbiter side table
        for (int i = 0; i < NVEC; i++) begin
            {tb_req, tb_ack, tb_done} = ARB_VEC[i][4:2];
            step();
            chk({vec_tag(i), " grant"}, arb_grant_o, ARB_VEC[i][1]);
            chk({vec_tag(i), " hold"},  dm_hold,     ARB_VEC[i][0]);
        end
        tb_req = 1'b0; tb_ack = 1'b0;

        // Requester: plain claim
        tb_want = 1'b1;
        step();
        chk("R8 req after want", alt_req_o, 1'b1);
        tb_grant = 1'b1;
        step(); step();
        chk("R8 no claim before sync", alt_ack_o, 1'b0);
        step();
        chk("R8 claim on third edge", alt_ack_o, 1'b1);
        chk("R10 req still up at claim", alt_req_o, 1'b1);
        step();
        chk("R10 req withdrawn", alt_req_o, 1'b0);
        chk("R10 ack held", alt_ack_o, 1'b1);
        chk("R10 owner", alt_owner, 1'b1);
        tb_want = 1'b0; tb_grant = 1'b0;
        step(); step(); step();
        chk("R11 owner kept without want or grant", alt_owner, 1'b1);
        tb_finish = 1'b1;
        step();
        tb_finish = 1'b0;
        chk("R11 ack cleared by finish", alt_ack_o, 1'b0);
        chk("R11 owner cleared by finish", alt_owner, 1'b0);

        // Requester: blocked by a foreign acknowledge
        tb_altack = 1'b1; tb_want = 1'b1; tb_grant = 1'b1;
        for (int k = 0; k < 6; k++) step();
        chk("R9 no claim while ack busy", alt_ack_o, 1'b0);
        chk("R9 request still pending", alt_req_o, 1'b1);
        tb_altack = 1'b0;
        step(); step();
        chk("R9 no claim before sync", alt_ack_o, 1'b0);
        step();
        chk("R9 claim after ack idle", alt_ack_o, 1'b1);
        tb_want = 1'b0; tb_grant = 1'b0;
        step();
        tb_finish = 1'b1;
        step();
        tb_finish = 1'b0;
        chk("R11 released", alt_ack_o, 1'b0);

        // Requester: withdrawal while waiting
        tb_want = 1'b1;
        step();
        chk("R12 req raised", alt_req_o, 1'b1);
        tb_want = 1'b0;
        step();
        chk("R12 req dropped", alt_req_o, 1'b0);
        step(); step();

        // Both sides looped together
        loopback = 1'b1; tb_done = 1'b1; tb_want = 1'b1;
        for (int k = 0; k < 20 && !alt_owner; k++) step();
        chk("R13 ownership reached", alt_owner, 1'b1);
        tb_want = 1'b0;
        chk("R13 default master held", dm_hold, 1'b1);
        step(); step(); step(); step();
        chk("R13 grant withdrawn while owned", arb_grant_o, 1'b0);
        chk("R13 hold while owned", dm_hold, 1'b1);
        tb_finish = 1'b1;
        step();
        tb_finish = 1'b0;
        for (int k = 0; k < 20 && dm_hold; k++) step();
        chk("R13 bus returned", dm_hold, 1'b0);
        chk("R13 requester idle", alt_req_o, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule